// File: doc/BRIEF.md
# Interrupt Flag and Request Unit

This unit collects three interrupt sources (a periodic tick, a time-of-day match and the end of a clock update) into one status byte and one interrupt request line. Each source pulse latches a flag whether or not that source is enabled. Software can therefore poll the flags, or enable some sources and take an interrupt from them.

Software reads the status byte with a read strobe that stays high for the whole read cycle. The flag bits hold still for the length of the read. When the strobe falls, every flag is cleared together. A source pulse that arrives while the strobe is high is parked and is applied in the cycle the read ends, so it is not lost. The request line is modelled as a pull-down enable for an open-drain pad: high means the line is pulled low, low means the line is released.

A control register holds the three source enables and a square-wave enable, which this unit stores for a neighbouring divider. A rising edge on the clock-set mode input clears the update-source enable.

Top module: `irq_status_unit`

## Requirements
- R1: A pulse on `evt_i[k]` in a cycle where `stat_rd` is low sets that source's flag, visible on `stat_o` after the next clock edge, whatever the enables hold.
- R2: `irq_pull_o` is 1 exactly when at least one source has both its flag and its enable set. Enable `en_o[0]` pairs with the periodic source, `en_o[1]` with the alarm source and `en_o[2]` with the update source.
- R3: `stat_o[7]` always equals `irq_pull_o`, and `stat_o[3:0]` always read 0.
- R4: In the first cycle after `stat_rd` falls, all flags set before the read began are cleared, and so is `stat_o[7]` unless an enabled source is re-flagged.
- R5: While `stat_rd` stays high, `stat_o[6:4]` does not change.
- R6: Pulses that arrive while `stat_rd` is high, or in the cycle it falls, appear as flags in the first cycle after the read ends.
- R7: Writing a 1 to the enable of a source whose flag is already set raises `irq_pull_o` after that same write edge.
- R8: A synchronous `rst` clears all flags, any parked pulses and all four enable bits, and releases the request line.
- R9: A rising edge of `set_mode` clears `en_o[2]`, taking priority over a write in that cycle. Holding `set_mode` high does not block later writes.
- R10: Flag positions in `stat_o` are periodic at bit 6, alarm at bit 5 and update at bit 4.
- R11: A write with `en_we` high loads `en_wdata` into `en_o` at the next edge. Bit 3 is the square-wave enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| evt_i | input | 3 | Source pulses: 0 periodic, 1 alarm, 2 update |
| en_we | input | 1 | Control write strobe |
| en_wdata | input | 4 | Control write data: source enables [2:0], square-wave enable [3] |
| set_mode | input | 1 | Clock-set mode level |
| stat_rd | input | 1 | Status read strobe, high for the whole read cycle |
| stat_o | output | 8 | Status byte |
| en_o | output | 4 | Current control bits |
| irq_pull_o | output | 1 | Open-drain pull-down enable for the request line |

## Verification
A flag that is wrong inside the unit shows on `stat_o[6:4]` one edge after the event or the read that caused it. When that flag is enabled, it also shows at once on both `irq_pull_o` and `stat_o[7]`. A lost parked pulse is visible only in the first cycle after the read ends, so the stimulus reads while pulses arrive and samples exactly there. An enable that is cleared wrongly by `set_mode`, or not cleared when it should be, appears on `en_o` one edge after the mode edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC     = 3;
    localparam int SRC_PER  = 0;
    localparam int SRC_ALM  = 1;
    localparam int SRC_UPD  = 2;
    localparam int STAT_W   = 8;
    localparam int SUM_BIT  = STAT_W - 1;
    localparam int FLAG_TOP = SUM_BIT - 1;
    localparam int CTRL_W   = NSRC + 1;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic     sqw_en;
        src_vec_t src_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_ACTIVE = 2'd1,
        RD_DONE   = 2'd2
    } rd_phase_t;

    function automatic logic [STAT_W-1:0] pack_status(input logic sum, input src_vec_t f);
        logic [STAT_W-1:0] s;
        s = '0;
        s[SUM_BIT] = sum;
        for (int i = 0; i < NSRC; i++) begin
            s[FLAG_TOP-i] = f[i];
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_read_track.sv
module irq_read_track
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd,
    output rd_phase_t phase
);
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= rd;
    end

    always_comb begin
        if (rd)        phase = RD_ACTIVE;
        else if (rd_q) phase = RD_DONE;
        else           phase = RD_IDLE;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_vec_t  evt,
    input  rd_phase_t phase,
    output src_vec_t  flags
);
    src_vec_t parked;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i]  <= 1'b0;
                parked[i] <= 1'b0;
            end else begin
                case (phase)
                    RD_ACTIVE: parked[i] <= parked[i] | evt[i];
                    RD_DONE: begin
                        flags[i]  <= parked[i] | evt[i];
                        parked[i] <= 1'b0;
                    end
                    default: flags[i] <= flags[i] | evt[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              set_mode,
    output ctrl_t             ctrl
);
    logic  set_q;
    logic  set_rise;
    ctrl_t ctrl_nx;

    assign set_rise = set_mode & ~set_q;

    always_comb begin
        ctrl_nx = ctrl;
        if (we) ctrl_nx = ctrl_t'(wdata);
        if (set_rise) ctrl_nx.src_en[SRC_UPD] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            set_q <= 1'b0;
        end else begin
            ctrl  <= ctrl_nx;
            set_q <= set_mode;
        end
    end
endmodule

// File: rtl/irq_request.sv
module irq_request
    import irq_pkg::*;
(
    input  src_vec_t          flags,
    input  src_vec_t          src_en,
    output logic              pull,
    output logic [STAT_W-1:0] status
);
    assign pull   = |(flags & src_en);
    assign status = pack_status(pull, flags);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              en_we,
    input  logic [CTRL_W-1:0] en_wdata,
    input  logic              set_mode,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_o,
    output logic [CTRL_W-1:0] en_o,
    output logic              irq_pull_o
);
    rd_phase_t phase;
    src_vec_t  flags;
    ctrl_t     ctrl;

    irq_read_track u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd    (stat_rd),
        .phase (phase)
    );

    irq_flag_bank u_flags (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_i),
        .phase (phase),
        .flags (flags)
    );

    irq_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .we       (en_we),
        .wdata    (en_wdata),
        .set_mode (set_mode),
        .ctrl     (ctrl)
    );

    irq_request u_req (
        .flags  (flags),
        .src_en (ctrl.src_en),
        .pull   (irq_pull_o),
        .status (stat_o)
    );

    assign en_o = ctrl;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] evt_i,
    input logic       en_we,
    input logic [3:0] en_wdata,
    input logic       set_mode,
    input logic       stat_rd,
    input logic [7:0] stat_o,
    input logic [3:0] en_o,
    input logic       irq_pull_o
);
    for (genvar i = 0; i < 3; i++) begin : g_evt
        // R1, R10
        p_flag_set_r1: assert property (@(posedge clk) disable iff (rst)
            (!stat_rd && evt_i[i]) |=> stat_o[6-i]);
    end

    p_pull_r2: assert property (@(posedge clk) disable iff (rst)
        irq_pull_o == ((stat_o[6] & en_o[0]) | (stat_o[5] & en_o[1]) | (stat_o[4] & en_o[2])));

    p_summary_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_o[7] == irq_pull_o) && (stat_o[3:0] == 4'h0));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && $past(stat_rd)) |-> $stable(stat_o[6:4]));

    p_enable_set_r7: assert property (@(posedge clk) disable iff (rst)
        (en_we && en_wdata[0] && stat_o[6] && !stat_rd && !$past(stat_rd)) |=> irq_pull_o);

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (stat_o == 8'h00) && (en_o == 4'h0) && !irq_pull_o);

    p_set_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(set_mode) |=> !en_o[2]);

    p_write_r11: assert property (@(posedge clk) disable iff (rst)
        (en_we && !$rose(set_mode)) |=> (en_o == $past(en_wdata)));
endmodule

bind irq_status_unit irq_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .en_we      (en_we),
    .en_wdata   (en_wdata),
    .set_mode   (set_mode),
    .stat_rd    (stat_rd),
    .stat_o     (stat_o),
    .en_o       (en_o),
    .irq_pull_o (irq_pull_o)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] evt_i = '0;
    logic       en_we = 1'b0;
    logic [3:0] en_wdata = '0;
    logic       set_mode = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_o;
    logic [3:0] en_o;
    logic       irq_pull_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_status_unit u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .en_we(en_we), .en_wdata(en_wdata),
        .set_mode(set_mode), .stat_rd(stat_rd), .stat_o(stat_o), .en_o(en_o),
        .irq_pull_o(irq_pull_o)
    );

    // fields: evt[22:20] we[19] wdata[18:15] set[14] rd[13] stat[12:5] irq[4] en[3:0]
    localparam int NV = 14;
    localparam logic [22:0] VECS [0:NV-1] = '{
        {3'b001, 1'b0, 4'h0, 1'b0, 1'b0, 8'h40, 1'b0, 4'h0},  // R1 periodic flag, not enabled
        {3'b000, 1'b1, 4'h1, 1'b0, 1'b0, 8'hC0, 1'b1, 4'h1},  // R7 enable an already-set flag
        {3'b100, 1'b0, 4'h0, 1'b0, 1'b0, 8'hD0, 1'b1, 4'h1},  // R10 update flag at bit 4
        {3'b010, 1'b0, 4'h0, 1'b0, 1'b1, 8'hD0, 1'b1, 4'h1},  // R5 alarm arrives mid-read
        {3'b000, 1'b0, 4'h0, 1'b0, 1'b1, 8'hD0, 1'b1, 4'h1},  // R5 still held
        {3'b000, 1'b0, 4'h0, 1'b0, 1'b0, 8'h20, 1'b0, 4'h1},  // R6 parked alarm appears
        {3'b000, 1'b1, 4'h2, 1'b0, 1'b0, 8'hA0, 1'b1, 4'h2},  // R7 alarm enable
        {3'b000, 1'b0, 4'h0, 1'b0, 1'b1, 8'hA0, 1'b1, 4'h2},  // R5 read
        {3'b000, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 4'h2},  // R4 cleared by read
        {3'b000, 1'b1, 4'h4, 1'b0, 1'b0, 8'h00, 1'b0, 4'h4},  // R2 enable without flag
        {3'b000, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 1'b0, 4'h0},  // R9 set rise clears update enable
        {3'b000, 1'b1, 4'h4, 1'b1, 1'b0, 8'h00, 1'b0, 4'h4},  // R9 set held, write allowed
        {3'b100, 1'b0, 4'h0, 1'b0, 1'b0, 8'h90, 1'b1, 4'h4},  // R3 summary mirrors pull
        {3'b000, 1'b1, 4'hC, 1'b0, 1'b0, 8'h90, 1'b1, 4'hC}   // R11 square-wave enable bit 3
    };
    localparam int VREQ [0:NV-1] = '{1, 7, 10, 5, 5, 6, 7, 5, 4, 2, 9, 9, 3, 11};

    task automatic chk(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic expect_all(input int req, input logic [7:0] s, input logic q, input logic [3:0] e);
        chk(req, "stat_o", stat_o, s);
        chk(req, "irq_pull_o", {7'b0, irq_pull_o}, {7'b0, q});
        chk(req, "en_o", {4'b0, en_o}, {4'b0, e});
    endtask

    task automatic step(input logic [2:0] ev, input logic we, input logic [3:0] wd,
                        input logic st, input logic rd);
        evt_i = ev; en_we = we; en_wdata = wd; set_mode = st; stat_rd = rd;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect_all(8, 8'h00, 1'b0, 4'h0);  // R8 state after reset

        for (int v = 0; v < NV; v++) begin
            step(VECS[v][22:20], VECS[v][19], VECS[v][18:15], VECS[v][14], VECS[v][13]);
            expect_all(VREQ[v], VECS[v][12:5], VECS[v][4], VECS[v][3:0]);
        end

        // R8: reset with flags and enables set
        rst = 1'b1;
        step(3'b000, 1'b0, 4'h0, 1'b0, 1'b0);
        rst = 1'b0;
        expect_all(8, 8'h00, 1'b0, 4'h0);

        // R6: all sources pulse in the first read cycle, deferred
        step(3'b111, 1'b0, 4'h0, 1'b0, 1'b1);
        expect_all(6, 8'h00, 1'b0, 4'h0);
        step(3'b000, 1'b0, 4'h0, 1'b0, 1'b0);
        expect_all(6, 8'h70, 1'b0, 4'h0);

        // R9: set rises in the same cycle as a write; R7 raises pull at once
        step(3'b000, 1'b1, 4'h7, 1'b1, 1'b0);
        expect_all(9, 8'hF0, 1'b1, 4'h3);

        // R6: pulse in the cycle the read ends is kept; R4 clears the rest
        step(3'b000, 1'b0, 4'h0, 1'b1, 1'b1);
        expect_all(5, 8'hF0, 1'b1, 4'h3);
        step(3'b001, 1'b0, 4'h0, 1'b1, 1'b0);
        expect_all(6, 8'hC0, 1'b1, 4'h3);

        // R4: a plain read with no new pulse empties the status
        step(3'b000, 1'b0, 4'h0, 1'b0, 1'b1);
        step(3'b000, 1'b0, 4'h0, 1'b0, 1'b0);
        expect_all(4, 8'h00, 1'b0, 4'h3);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule